// File: doc/BRIEF.md
# FSK Manchester Identifier Frame Generator

This block turns a 44-bit identifier into the sample stream for one frame of a frequency-shift-keyed low-frequency tag response. The stream is made of three kinds of symbol. A slow burst repeats a short high run inside an 8-sample period. A fast burst repeats a slightly longer high run inside a 10-sample period. A 4-sample spacer marks nibble boundaries. Each data bit is sent as an ordered pair of bursts, which gives a Manchester code. A header whose burst pair cannot occur in data marks the start of the frame.

The host places the identifier on two 32-bit words and pulses `start`. The stream then advances one sample for each `adv` strobe, so an external carrier-rate tick sets the pace. When the last sample has been consumed, `frame_done` pulses for one cycle. A request whose upper word does not fit in 12 bits is refused, and no frame is produced. Repeating frames and driving the antenna are left to the surrounding logic.

Top module: `fsk_frame_gen`

## Requirements
- R1: While reset is asserted and right after it, `sample` and `frame_done` are 0.
- R2: A slow burst is 48 samples: the period 11000000 repeated six times.
- R3: A fast burst is 50 samples: the period 1110000000 repeated five times.
- R4: A spacer of the 4 samples 1100 comes before every identifier bit whose index modulo 4 is 3 (bits 43, 39, ..., 3). Each group of four bits therefore opens with a spacer.
- R5: The identifier is `{id_hi[11:0], id_lo}`, sent from bit 43 down to bit 0. A 1 is a fast burst followed by a slow burst. A 0 is a slow burst followed by a fast burst.
- R6: A frame opens with a spacer, then slow, slow, slow, fast. Its total length is 4554 samples.
- R7: The sample index moves only on a cycle with `adv` high. With `adv` low, `sample` holds its value.
- R8: `frame_done` is high for exactly one cycle. That cycle is the one after the clock edge that consumes the last sample. `sample` is 0 from that cycle on.
- R9: A `start` with `id_hi` greater than 0xFFF is refused: no samples, no `frame_done`. `id_hi` equal to 0xFFF is accepted.
- R10: A `start` that arrives while a frame is being sent has no effect on that frame.
- R11: When no frame is active, `sample` is 0, whatever `adv` does. On the cycle after an accepted `start`, `sample` shows the first sample of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a frame. Taken only when idle. |
| id_hi | input | 32 | Upper identifier word. Only values up to 0xFFF are accepted. |
| id_lo | input | 32 | Lower 32 identifier bits |
| adv | input | 1 | Sample-advance strobe |
| sample | output | 1 | Current sample of the frame |
| frame_done | output | 1 | One-cycle pulse after the last sample |

## Verification
Three identifiers are sent and compared sample by sample against a stream built from the coding rules:
- All zeros shows the slow-then-fast order of every bit.
- All ones (upper word 0xFFF) shows the reversed order and the upper accepted bound.
- A mixed value separates bit order and nibble spacer placement from a uniform pattern.

The all-ones frame is sent with gaps in the strobe to show that the sample holds. The mixed frame receives a competing `start` halfway through, which must leave the frame unchanged. An upper word of 0x1000 must give a silent output with no completion pulse.

// File: rtl/fsk_frame_pkg.sv
package fsk_frame_pkg;

    localparam int HI_BITS   = 12;
    localparam int LO_BITS   = 32;
    localparam int ID_BITS   = HI_BITS + LO_BITS;
    localparam int NIB       = 4;

    localparam int SLOW_DIV  = 8;
    localparam int SLOW_REPS = 6;
    localparam int SLOW_ON   = 2;
    localparam int FAST_DIV  = 10;
    localparam int FAST_REPS = 5;
    localparam int FAST_ON   = 3;
    localparam int GAP_LEN   = 4;
    localparam int GAP_ON    = 2;
    localparam int LEAD_SYMS = 5;

    localparam int SLOW_LEN  = SLOW_DIV * SLOW_REPS;
    localparam int FAST_LEN  = FAST_DIV * FAST_REPS;
    localparam int MAX_LEN   = (SLOW_LEN > FAST_LEN) ? SLOW_LEN : FAST_LEN;
    localparam int POS_W     = $clog2(MAX_LEN);
    localparam int BIT_W     = $clog2(ID_BITS);
    localparam int LEAD_W    = $clog2(LEAD_SYMS);

    localparam logic [31:0] HI_MAX = 32'((64'd1 << HI_BITS) - 1);

    typedef enum logic [1:0] {
        SYM_GAP  = 2'd0,
        SYM_SLOW = 2'd1,
        SYM_FAST = 2'd2
    } sym_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LEAD  = 3'd1,
        ST_GAP   = 3'd2,
        ST_HALF0 = 3'd3,
        ST_HALF1 = 3'd4
    } stage_t;

    typedef struct packed {
        stage_t              stage;
        logic [LEAD_W-1:0]   lead;
        logic [BIT_W-1:0]    bit_idx;
    } seq_t;

    function automatic int sym_len(sym_t s);
        case (s)
            SYM_SLOW: return SLOW_LEN;
            SYM_FAST: return FAST_LEN;
            default:  return GAP_LEN;
        endcase
    endfunction

    function automatic logic sym_level(sym_t s, logic [POS_W-1:0] pos);
        case (s)
            SYM_SLOW: return (int'(pos) % SLOW_DIV) < SLOW_ON;
            SYM_FAST: return (int'(pos) % FAST_DIV) < FAST_ON;
            default:  return int'(pos) < GAP_ON;
        endcase
    endfunction

    // header: spacer, three slow bursts (invalid pair + first half), fast
    function automatic sym_t lead_sym(logic [LEAD_W-1:0] idx);
        if (idx == '0)
            return SYM_GAP;
        else if (int'(idx) == LEAD_SYMS - 1)
            return SYM_FAST;
        else
            return SYM_SLOW;
    endfunction

    function automatic stage_t bit_entry(logic [BIT_W-1:0] idx);
        return ((int'(idx) % NIB) == NIB - 1) ? ST_GAP : ST_HALF0;
    endfunction

endpackage

// File: rtl/fsk_burst_gen.sv
module fsk_burst_gen
    import fsk_frame_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic adv,
    input  sym_t sym,
    output logic sample,
    output logic sym_end
);

    logic [POS_W-1:0] pos;
    logic             last;

    assign last    = (int'(pos) == sym_len(sym) - 1);
    assign sym_end = run && adv && last;
    assign sample  = run && sym_level(sym, pos);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pos <= '0;
        end else if (adv) begin
            pos <= last ? '0 : pos + 1'b1;
        end
    end

endmodule

// File: rtl/fsk_frame_seq.sv
module fsk_frame_seq
    import fsk_frame_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [ID_BITS-1:0] id,
    input  logic               sym_end,
    output logic               busy,
    output sym_t               sym,
    output logic               done
);

    seq_t               st;
    logic [ID_BITS-1:0] id_q;
    logic               cur_bit;

    assign busy    = (st.stage != ST_IDLE);
    assign cur_bit = id_q[st.bit_idx];

    always_comb begin
        case (st.stage)
            ST_LEAD:  sym = lead_sym(st.lead);
            ST_HALF0: sym = cur_bit ? SYM_FAST : SYM_SLOW;
            ST_HALF1: sym = cur_bit ? SYM_SLOW : SYM_FAST;
            default:  sym = SYM_GAP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st.stage   <= ST_IDLE;
            st.lead    <= '0;
            st.bit_idx <= '0;
            id_q       <= '0;
            done       <= 1'b0;
        end else begin
            done <= 1'b0;
            if (st.stage == ST_IDLE) begin
                if (load) begin
                    st.stage   <= ST_LEAD;
                    st.lead    <= '0;
                    st.bit_idx <= BIT_W'(ID_BITS - 1);
                    id_q       <= id;
                end
            end else if (sym_end) begin
                case (st.stage)
                    ST_LEAD: begin
                        if (int'(st.lead) == LEAD_SYMS - 1)
                            st.stage <= bit_entry(st.bit_idx);
                        else
                            st.lead <= st.lead + 1'b1;
                    end
                    ST_GAP:   st.stage <= ST_HALF0;
                    ST_HALF0: st.stage <= ST_HALF1;
                    ST_HALF1: begin
                        if (st.bit_idx == '0) begin
                            st.stage <= ST_IDLE;
                            done     <= 1'b1;
                        end else begin
                            st.bit_idx <= st.bit_idx - 1'b1;
                            st.stage   <= bit_entry(st.bit_idx - 1'b1);
                        end
                    end
                    default: st.stage <= ST_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/fsk_frame_gen.sv
module fsk_frame_gen
    import fsk_frame_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [31:0] id_hi,
    input  logic [31:0] id_lo,
    input  logic        adv,
    output logic        sample,
    output logic        frame_done
);

    logic               load;
    logic               busy;
    logic               sym_end;
    sym_t               sym;
    logic [ID_BITS-1:0] id;

    assign load = start && (id_hi <= HI_MAX);
    assign id   = {id_hi[HI_BITS-1:0], id_lo[LO_BITS-1:0]};

    fsk_frame_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .id      (id),
        .sym_end (sym_end),
        .busy    (busy),
        .sym     (sym),
        .done    (frame_done)
    );

    fsk_burst_gen u_burst (
        .clk     (clk),
        .rst     (rst),
        .run     (busy),
        .adv     (adv),
        .sym     (sym),
        .sample  (sample),
        .sym_end (sym_end)
    );

endmodule

// File: rtl/fsk_frame_chk.sv
module fsk_frame_chk
    import fsk_frame_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic [31:0] id_hi,
    input logic        adv,
    input logic        busy,
    input logic        sample,
    input logic        frame_done
);

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

    a_r8_done_after_frame: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> (!busy && $past(busy) && $past(adv)));

    a_r11_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sample);

    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && !adv) |=> (busy && $stable(sample)));

    a_r9_refuse: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && (id_hi > HI_MAX)) |=> !busy);

    a_r11_first_sample: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && (id_hi <= HI_MAX)) |=> (busy && sample));

    a_r10_busy_start: assert property (@(posedge clk) disable iff (rst)
        (start && busy && !adv) |=> busy);

endmodule

bind fsk_frame_gen fsk_frame_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .id_hi      (id_hi),
    .adv        (adv),
    .busy       (busy),
    .sample     (sample),
    .frame_done (frame_done)
);

// File: tb/tb_fsk_frame_gen.sv
module tb_fsk_frame_gen;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        adv = 1'b0;
    logic [31:0] id_hi = '0;
    logic [31:0] id_lo = '0;
    logic        sample;
    logic        frame_done;

    int    n_chk  = 0;
    int    n_fail = 0;
    bit    exp_q[$];
    string tag_q[$];
    bit    mon_en = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    fsk_frame_gen dut (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .id_hi      (id_hi),
        .id_lo      (id_lo),
        .adv        (adv),
        .sample     (sample),
        .frame_done (frame_done)
    );

    task automatic check(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #(CLK_P/4);
    endtask

    task automatic push_sym(int kind, string tag);
        if (kind == 0) begin
            for (int k = 0; k < 4; k++) begin exp_q.push_back(k < 2); tag_q.push_back(tag); end
        end else if (kind == 8) begin
            for (int k = 0; k < 48; k++) begin exp_q.push_back((k % 8) < 2); tag_q.push_back(tag); end
        end else begin
            for (int k = 0; k < 50; k++) begin exp_q.push_back((k % 10) < 3); tag_q.push_back(tag); end
        end
    endtask

    task automatic build(logic [31:0] hi, logic [31:0] lo);
        bit [43:0] idv;
        idv = {hi[11:0], lo};
        push_sym(0, "R6 header spacer");
        push_sym(8, "R6 header slow");
        push_sym(8, "R6 header slow");
        push_sym(8, "R6 header slow");
        push_sym(10, "R6 header fast");
        for (int i = 43; i >= 0; i--) begin
            if ((i % 4) == 3) push_sym(0, "R4 nibble spacer");
            if (idv[i]) begin
                push_sym(10, "R5,R3 one first half");
                push_sym(8, "R5,R2 one second half");
            end else begin
                push_sym(8, "R5,R2 zero first half");
                push_sym(10, "R5,R3 zero second half");
            end
        end
    endtask

    // monitor: pops an expected sample whenever a strobe consumes one
    always @(negedge clk) begin
        if (mon_en) begin
            if (frame_done && exp_q.size() != 0)
                check("R8 early done", frame_done, 1'b0);
            if (adv) begin
                if (exp_q.size() == 0) begin
                    check("R6 extra sample", 1'b1, 1'b0);
                end else begin
                    check(tag_q.pop_front(), sample, exp_q.pop_front());
                end
            end else if (exp_q.size() != 0) begin
                check("R7 hold without strobe", sample, exp_q[0]);
            end
        end
    end

    task automatic run_frame(logic [31:0] hi, logic [31:0] lo, bit stall, bit poke);
        int total;
        build(hi, lo);
        total = exp_q.size();
        tick();
        id_hi = hi;
        id_lo = lo;
        start = 1'b1;
        tick();
        start = 1'b0;
        mon_en = 1'b1;
        for (int k = 0; k < total; k++) begin
            if (stall && (k % 37) == 5) begin
                adv = 1'b0;
                tick(); tick(); tick();
            end
            if (poke && k == 100) begin
                start = 1'b1;   // R10: competing request mid-frame
                id_hi = 32'h0;
                id_lo = 32'h0;
            end
            adv = 1'b1;
            tick();
            start = 1'b0;
        end
        adv = 1'b0;
        mon_en = 1'b0;
        @(negedge clk);
        check("R8 done pulse", frame_done, 1'b1);
        check("R6 frame length", exp_q.size() == 0, 1'b1);
        check("R8 sample zero after frame", sample, 1'b0);
        tick();
        @(negedge clk);
        check("R8 done single cycle", frame_done, 1'b0);
        exp_q.delete();
        tag_q.delete();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 sample in reset", sample, 1'b0);
        check("R1 done in reset", frame_done, 1'b0);
        tick();
        rst = 1'b0;
        @(negedge clk);
        check("R1 sample after reset", sample, 1'b0);
        check("R1 done after reset", frame_done, 1'b0);

        // R11: idle stays silent with strobes running
        adv = 1'b1;
        for (int k = 0; k < 8; k++) begin
            tick();
            @(negedge clk);
            check("R11 idle sample", sample, 1'b0);
            check("R11 idle done", frame_done, 1'b0);
        end
        adv = 1'b0;

        // R5: all-zero identifier
        run_frame(32'h0, 32'h0, 1'b0, 1'b0);
        // R9 boundary, R7 stalls: all-ones identifier
        run_frame(32'h0000_0FFF, 32'hFFFF_FFFF, 1'b1, 1'b0);
        // R4/R5 mixed pattern with R10 competing start
        run_frame(32'h0000_0A5C, 32'h3C96_E10F, 1'b0, 1'b1);

        // R9: oversize upper word refused
        tick();
        id_hi = 32'h0000_1000;
        id_lo = 32'h1234_5678;
        start = 1'b1;
        tick();
        start = 1'b0;
        adv = 1'b1;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            check("R9 refused sample", sample, 1'b0);
            check("R9 refused done", frame_done, 1'b0);
            tick();
        end
        adv = 1'b0;

        // accepted again after refusal
        run_frame(32'h0000_0123, 32'h8000_0001, 1'b0, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule